// File: doc/BRIEF.md
# DAC configuration and update controller

This block owns the 12-bit control word of an eight-channel digital-to-analog converter and decides when each channel's output latch is reloaded. A register port lets software write and read the control word and announce a write to any channel's data register; the channel data itself lives elsewhere, and this block only notes which channels were touched. Each channel carries a dirty flag that is set by a write and cleared when a load is issued, so a load strobes only the channels written since the previous load.

A load is requested either by setting the self-clearing load bit of the control word or by a falling edge on the active-low `ldac_n` pin. When the correction engine is enabled and reports busy, the request waits and is issued on the first clock edge at which busy is sampled low. The control word also drives two group power-down flags, two group gain selects (with a one-cycle offset-reload pulse whenever a write changes one of them), the correction enable, the readback-source select and a self-clearing soft reset that behaves like the hardware reset.

Top module: `dac_cfg_ctrl`

## Requirements
- R1: After reset the control word reads 0x800: readback select is 1, every other bit is 0, and no load strobe, offset-reload pulse or soft-reset pulse is active.
- R2: Bits 2..0 and the busy bit 5 ignore writes; bits 2..0 always read 0.
- R3: Control bit 11 drives `rd_from_dac`, bit 8 drives `pd_grp_a` (channels 0-3), bit 7 drives `pd_grp_b` (channels 4-7), bit 6 drives `corr_en`; each follows the word written in the cycle after the write edge.
- R4: A write with bit 10 set while `ldac_n` is high makes bit 10 read 1 in the cycle after the write edge; with no busy hold, the strobes appear in the cycle after the next edge and bit 10 reads 0 again.
- R5: `ld_strobe` bit i is 1 for exactly one cycle only if channel i was written since the last issued load; a load with no dirty channel produces no strobe.
- R6: A channel write sampled on the same edge that issues a load is not strobed by it and is strobed by the following load.
- R7: While `ldac_n` is low, a write with bit 10 set is ignored: bit 10 stays 0 and no strobe follows.
- R8: A high-to-low transition on `ldac_n`, sampled at an edge, requests a load exactly like bit 10 (bit 10 reads 1 until the load issues).
- R9: With bit 6 set and `corr_busy` high, a pending load is held (no strobe, bit 10 stays 1) and issues at the first edge where `corr_busy` is sampled low; with bit 6 clear, `corr_busy` does not delay a load.
- R10: Bit 5 reads 1 exactly when bit 6 is 1 and `corr_busy` is high.
- R11: A control write that changes bit 4 (group A gain) or bit 3 (group B gain) raises `ofs_reload_a` or `ofs_reload_b` for one cycle after the write edge; writing an unchanged gain raises no pulse.
- R12: Writing bit 9 as 1 raises `soft_rst_pulse` (and bit 9 reads 1) for one cycle; at the next edge the whole block returns to its reset state, including clearing all dirty flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 12 | Control word write data |
| cfg_rdata | output | 12 | Control word readback |
| ch_wr | input | 1 | Channel data write announcement |
| ch_idx | input | 3 | Channel index of the data write |
| ldac_n | input | 1 | Active-low load pin, falling edge requests a load |
| corr_busy | input | 1 | Correction engine still working |
| ld_strobe | output | 8 | One-cycle latch-load strobe per channel |
| pd_grp_a | output | 1 | Power-down for channels 0-3 |
| pd_grp_b | output | 1 | Power-down for channels 4-7 |
| gain_sel_a | output | 1 | Gain select, group A |
| gain_sel_b | output | 1 | Gain select, group B |
| ofs_reload_a | output | 1 | Offset reload pulse, group A |
| ofs_reload_b | output | 1 | Offset reload pulse, group B |
| soft_rst_pulse | output | 1 | One-cycle soft reset indication |
| rd_from_dac | output | 1 | Readback source: 1 processed data, 0 raw input |
| corr_en | output | 1 | Correction engine enable |

## Verification
The load issue edge and a new channel write can coincide, so the bench announces a write to channel 3 exactly on the edge that issues a load of channel 0 and judges that the strobe carries only channel 0 while the next load carries only channel 3. A second collision is a soft reset written together with gain changes: the bench checks that the offset pulses and the soft-reset pulse show in the same cycle and that the following cycle reads the reset word with previously dirty channels forgotten.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

    localparam int CFG_W = 12;

    // Bit positions of the control word (decoded by software and neighbours)
    localparam int B_RDSEL = 11;
    localparam int B_LOAD  = 10;
    localparam int B_SRST  = 9;
    localparam int B_PDA   = 8;
    localparam int B_PDB   = 7;
    localparam int B_CEN   = 6;
    localparam int B_BUSY  = 5;
    localparam int B_GA    = 4;
    localparam int B_GB    = 3;

    // Stored, writable part of the control word
    typedef struct packed {
        logic rdsel;
        logic pd_a;
        logic pd_b;
        logic corr_en;
        logic gain_a;
        logic gain_b;
    } cfg_t;

    localparam cfg_t CFG_RST = '{rdsel: 1'b1, default: 1'b0};

    // Assemble the readback word from stored fields and live status
    function automatic logic [CFG_W-1:0] cfg_to_word(
        input cfg_t c,
        input logic load_pend,
        input logic srst,
        input logic busy
    );
        logic [CFG_W-1:0] w;
        w          = '0;
        w[B_RDSEL] = c.rdsel;
        w[B_LOAD]  = load_pend;
        w[B_SRST]  = srst;
        w[B_PDA]   = c.pd_a;
        w[B_PDB]   = c.pd_b;
        w[B_CEN]   = c.corr_en;
        w[B_BUSY]  = c.corr_en & busy;
        w[B_GA]    = c.gain_a;
        w[B_GB]    = c.gain_b;
        return w;
    endfunction

endpackage

// File: rtl/dcu_cfg_reg.sv
module dcu_cfg_reg
    import dcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg_q,
    output logic             ofs_a_q,
    output logic             ofs_b_q,
    output logic             srst_q
);

    logic int_rst;
    cfg_t cfg_d;
    logic unused_wbits;

    assign int_rst      = rst | srst_q;
    assign unused_wbits = ^{cfg_wdata[B_LOAD], cfg_wdata[B_BUSY], cfg_wdata[2:0]};

    always_comb begin
        cfg_d         = cfg_q;
        if (cfg_wr) begin
            cfg_d.rdsel   = cfg_wdata[B_RDSEL];
            cfg_d.pd_a    = cfg_wdata[B_PDA];
            cfg_d.pd_b    = cfg_wdata[B_PDB];
            cfg_d.corr_en = cfg_wdata[B_CEN];
            cfg_d.gain_a  = cfg_wdata[B_GA];
            cfg_d.gain_b  = cfg_wdata[B_GB];
        end
    end

    always_ff @(posedge clk) begin
        if (int_rst) begin
            cfg_q   <= CFG_RST;
            ofs_a_q <= 1'b0;
            ofs_b_q <= 1'b0;
        end else begin
            cfg_q   <= cfg_d;
            ofs_a_q <= cfg_wr && (cfg_wdata[B_GA] != cfg_q.gain_a);
            ofs_b_q <= cfg_wr && (cfg_wdata[B_GB] != cfg_q.gain_b);
        end
    end

    // Soft reset request lives one cycle, then resets everything else
    always_ff @(posedge clk) begin
        if (rst) srst_q <= 1'b0;
        else     srst_q <= cfg_wr && cfg_wdata[B_SRST] && !srst_q;
    end

endmodule

// File: rtl/dcu_dirty_bank.sv
module dcu_dirty_bank #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [CH_W-1:0]   set_idx,
    input  logic              clr_all,
    output logic [NUM_CH-1:0] dirty_q
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = set_en && (set_idx == CH_W'(i));
        always_ff @(posedge clk) begin
            if (rst) dirty_q[i] <= 1'b0;
            else     dirty_q[i] <= (dirty_q[i] & ~clr_all) | hit;
        end
    end

endmodule

// File: rtl/dcu_load_seq.sv
module dcu_load_seq #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ldac_n,
    input  logic              ld_bit_wr,
    input  logic              corr_en,
    input  logic              corr_busy,
    input  logic              ch_wr,
    input  logic [CH_W-1:0]   ch_idx,
    output logic              pend_q,
    output logic [NUM_CH-1:0] dirty_q,
    output logic [NUM_CH-1:0] ld_strobe_q
);

    logic ldac_q;
    logic ldac_fall;
    logic req;
    logic hold;
    logic issue;

    always_ff @(posedge clk) ldac_q <= ldac_n;

    assign ldac_fall = ldac_q & ~ldac_n;
    assign req       = (ld_bit_wr & ldac_n) | ldac_fall;
    assign hold      = corr_en & corr_busy;
    assign issue     = pend_q & ~hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            ld_strobe_q <= '0;
        end else begin
            pend_q      <= req | (pend_q & ~issue);
            ld_strobe_q <= issue ? dirty_q : '0;
        end
    end

    dcu_dirty_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dirty (
        .clk     (clk),
        .rst     (rst),
        .set_en  (ch_wr),
        .set_idx (ch_idx),
        .clr_all (issue),
        .dirty_q (dirty_q)
    );

endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
    import dcu_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              ch_wr,
    input  logic [CH_W-1:0]   ch_idx,
    input  logic              ldac_n,
    input  logic              corr_busy,
    output logic [NUM_CH-1:0] ld_strobe,
    output logic              pd_grp_a,
    output logic              pd_grp_b,
    output logic              gain_sel_a,
    output logic              gain_sel_b,
    output logic              ofs_reload_a,
    output logic              ofs_reload_b,
    output logic              soft_rst_pulse,
    output logic              rd_from_dac,
    output logic              corr_en
);

    cfg_t              cfg_q;
    logic              srst_q;
    logic              int_rst;
    logic              load_pend;
    logic [NUM_CH-1:0] dirty_q;

    assign int_rst = rst | srst_q;

    dcu_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .ofs_a_q   (ofs_reload_a),
        .ofs_b_q   (ofs_reload_b),
        .srst_q    (srst_q)
    );

    dcu_load_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
        .clk         (clk),
        .rst         (int_rst),
        .ldac_n      (ldac_n),
        .ld_bit_wr   (cfg_wr & cfg_wdata[B_LOAD]),
        .corr_en     (cfg_q.corr_en),
        .corr_busy   (corr_busy),
        .ch_wr       (ch_wr),
        .ch_idx      (ch_idx),
        .pend_q      (load_pend),
        .dirty_q     (dirty_q),
        .ld_strobe_q (ld_strobe)
    );

    assign cfg_rdata      = cfg_to_word(cfg_q, load_pend, srst_q, corr_busy);
    assign pd_grp_a       = cfg_q.pd_a;
    assign pd_grp_b       = cfg_q.pd_b;
    assign gain_sel_a     = cfg_q.gain_a;
    assign gain_sel_b     = cfg_q.gain_b;
    assign rd_from_dac    = cfg_q.rdsel;
    assign corr_en        = cfg_q.corr_en;
    assign soft_rst_pulse = srst_q;

endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [11:0]       cfg_rdata,
    input logic [NUM_CH-1:0] ld_strobe,
    input logic [NUM_CH-1:0] dirty,
    input logic              pend,
    input logic              corr_en,
    input logic              corr_busy,
    input logic              gain_sel_a,
    input logic              gain_sel_b,
    input logic              ofs_reload_a,
    input logic              ofs_reload_b,
    input logic              soft_rst_pulse
);

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[2:0] == 3'b000);

    a_r10_busy_masked: assert property (@(posedge clk) disable iff (rst)
        !corr_en |-> !cfg_rdata[5]);

    a_r4_strobe_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (|ld_strobe) |-> $past(pend));

    a_r5_strobe_dirty_only: assert property (@(posedge clk) disable iff (rst)
        (ld_strobe & ~$past(dirty)) == '0);

    a_r9_no_issue_while_busy: assert property (@(posedge clk) disable iff (rst)
        (|ld_strobe) |-> !($past(corr_en) && $past(corr_busy)));

    a_r11_reload_a_on_change: assert property (@(posedge clk) disable iff (rst)
        ofs_reload_a |-> (gain_sel_a != $past(gain_sel_a)));

    a_r11_reload_b_on_change: assert property (@(posedge clk) disable iff (rst)
        ofs_reload_b |-> (gain_sel_b != $past(gain_sel_b)));

    a_r12_soft_reset_restores: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |=> (cfg_rdata == 12'h800 && !soft_rst_pulse && dirty == '0));

endmodule

bind dac_cfg_ctrl dcu_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_rdata      (cfg_rdata),
    .ld_strobe      (ld_strobe),
    .dirty          (dirty_q),
    .pend           (load_pend),
    .corr_en        (corr_en),
    .corr_busy      (corr_busy),
    .gain_sel_a     (gain_sel_a),
    .gain_sel_b     (gain_sel_b),
    .ofs_reload_a   (ofs_reload_a),
    .ofs_reload_b   (ofs_reload_b),
    .soft_rst_pulse (soft_rst_pulse)
);

// File: tb/tb_dac_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_dac_cfg_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        ch_wr = 1'b0;
    logic [2:0]  ch_idx = '0;
    logic        ldac_n = 1'b1;
    logic        corr_busy = 1'b0;
    logic [7:0]  ld_strobe;
    logic        pd_grp_a, pd_grp_b, gain_sel_a, gain_sel_b;
    logic        ofs_reload_a, ofs_reload_b, soft_rst_pulse, rd_from_dac, corr_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dac_cfg_ctrl dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ch_wr(ch_wr), .ch_idx(ch_idx),
        .ldac_n(ldac_n), .corr_busy(corr_busy), .ld_strobe(ld_strobe),
        .pd_grp_a(pd_grp_a), .pd_grp_b(pd_grp_b),
        .gain_sel_a(gain_sel_a), .gain_sel_b(gain_sel_b),
        .ofs_reload_a(ofs_reload_a), .ofs_reload_b(ofs_reload_b),
        .soft_rst_pulse(soft_rst_pulse), .rd_from_dac(rd_from_dac),
        .corr_en(corr_en)
    );

    // {write word, expected readback, {rdsel,pd_a,pd_b,cen,ga,gb}, {ofs_a,ofs_b}}
    localparam logic [31:0] VEC [8] = '{
        {12'h000, 12'h000, 6'b000000, 2'b00},
        {12'h1FF, 12'h1D8, 6'b011111, 2'b11},
        {12'h810, 12'h810, 6'b100010, 2'b01},
        {12'h808, 12'h808, 6'b100001, 2'b11},
        {12'h808, 12'h808, 6'b100001, 2'b00},
        {12'h0C7, 12'h0C0, 6'b001100, 2'b01},
        {12'h900, 12'h900, 6'b110000, 2'b00},
        {12'h020, 12'h000, 6'b000000, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ch_write(input logic [2:0] idx);
        @(negedge clk);
        ch_wr = 1'b1; ch_idx = idx;
        @(negedge clk);
        ch_wr = 1'b0;
    endtask

    function automatic logic [5:0] outs();
        return {rd_from_dac, pd_grp_a, pd_grp_b, corr_en, gain_sel_a, gain_sel_b};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", cfg_rdata, 12'h800);
        chk("R1 reset outputs", {outs(), ofs_reload_a, ofs_reload_b, soft_rst_pulse}, 9'b100000000);
        chk("R1 reset strobes", ld_strobe, 8'h00);

        // Vector walk: R2, R3, R11
        for (int i = 0; i < 8; i++) begin
            cfg_write(VEC[i][31:20]);
            chk("R2 R3 readback", cfg_rdata, VEC[i][19:8]);
            chk("R3 field outputs", outs(), VEC[i][7:2]);
            chk("R11 offset pulses", {ofs_reload_a, ofs_reload_b}, VEC[i][1:0]);
            @(negedge clk);
            chk("R11 pulse one cycle", {ofs_reload_a, ofs_reload_b}, 2'b00);
        end

        // R4 / R5: load of dirty channels 1 and 5
        ch_write(3'd1);
        ch_write(3'd5);
        cfg_write(12'hC00);
        chk("R4 load bit pending", cfg_rdata[10], 1'b1);
        chk("R4 no strobe yet", ld_strobe, 8'h00);
        @(negedge clk);
        chk("R5 dirty strobes", ld_strobe, 8'h22);
        chk("R4 load bit clears", cfg_rdata[10], 1'b0);
        @(negedge clk);
        chk("R5 strobe one cycle", ld_strobe, 8'h00);
        cfg_write(12'hC00);
        @(negedge clk);
        chk("R5 no dirty no strobe", ld_strobe, 8'h00);

        // R6: channel write on the issue edge
        ch_write(3'd0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 12'hC00;
        @(negedge clk);
        cfg_wr = 1'b0; ch_wr = 1'b1; ch_idx = 3'd3;
        @(negedge clk);
        ch_wr = 1'b0;
        chk("R6 issue excludes late write", ld_strobe, 8'h01);
        cfg_write(12'hC00);
        @(negedge clk);
        chk("R6 late write next load", ld_strobe, 8'h08);

        // R9 / R10: hold while correction busy
        ch_write(3'd2);
        corr_busy = 1'b1;
        cfg_write(12'hC40);
        chk("R10 busy flag set", cfg_rdata[5], 1'b1);
        @(negedge clk);
        chk("R9 held no strobe", ld_strobe, 8'h00);
        @(negedge clk);
        chk("R9 still pending", cfg_rdata[10], 1'b1);
        corr_busy = 1'b0;
        @(negedge clk);
        chk("R9 issue after busy", ld_strobe, 8'h04);
        corr_busy = 1'b1;
        cfg_write(12'h800);
        chk("R10 busy masked", cfg_rdata[5], 1'b0);
        ch_write(3'd6);
        cfg_write(12'hC00);
        @(negedge clk);
        chk("R9 busy ignored when disabled", ld_strobe, 8'h40);
        corr_busy = 1'b0;

        // R7: load bit ignored while ldac_n low
        @(negedge clk);
        ldac_n = 1'b0;
        repeat (3) @(negedge clk);
        ch_write(3'd4);
        cfg_write(12'hC00);
        chk("R7 load bit ignored", cfg_rdata[10], 1'b0);
        @(negedge clk);
        chk("R7 no strobe", ld_strobe, 8'h00);
        @(negedge clk);
        chk("R7 still no strobe", ld_strobe, 8'h00);

        // R8: falling edge of ldac_n loads
        ldac_n = 1'b1;
        @(negedge clk);
        ldac_n = 1'b0;
        @(negedge clk);
        chk("R8 edge pending", cfg_rdata[10], 1'b1);
        @(negedge clk);
        chk("R8 edge strobes", ld_strobe, 8'h10);
        ldac_n = 1'b1;
        @(negedge clk);

        // R12: soft reset together with gain changes
        ch_write(3'd6);
        cfg_write(12'hB98);
        chk("R12 soft pulse", {soft_rst_pulse, cfg_rdata[9]}, 2'b11);
        chk("R11 pulses with soft reset", {ofs_reload_a, ofs_reload_b}, 2'b11);
        @(negedge clk);
        chk("R12 word restored", cfg_rdata, 12'h800);
        chk("R12 pulse gone", {soft_rst_pulse, pd_grp_a, pd_grp_b}, 3'b000);
        cfg_write(12'hC00);
        @(negedge clk);
        chk("R12 dirty cleared", ld_strobe, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule